// File: doc/BRIEF.md
# Programmable Asynchronous Memory Strobe Sequencer

This block drives the control strobes of one access to an asynchronous external memory or a NAND flash device. A one-clock start request launches either a read or a write. From then on a tick counter steps through a cycle of programmed length. Every strobe is low (active) over its own programmed window of ticks. The strobes are chip select (one of six lines), write enable, output enable, and a latch strobe that goes either to the address-latch pin or to the command-latch pin. A data-drive enable covers the whole of a write.

A granularity bit sets each tick to one or two functional clocks. Each of the chip-select, write-enable, output-enable and latch strobes has an extra-delay bit. When that bit is set, both edges of the strobe move half a clock later. Before a start request is taken, its settings are checked for consistency. A request with bad settings sets an error flag and launches nothing. The settings of an accepted request are captured at launch. A done pulse marks the end of every cycle.

Top module: `async_mem_strobe_seq`

## Requirements
- R1: After reset every strobe output is high, and data_oe_o, busy_o, done_o and cfg_err_o are low.
- R2: A tick lasts gran_i+1 clocks, and a cycle lasts N ticks, where N is wr_cyc_i for writes and rd_cyc_i for reads. Outputs show the first clock of tick 0 in the clock after the edge that accepts the start. busy_o is high from that edge through the last clock of the cycle.
- R3: On writes (write_i=1), we_n_o is low for ticks we_on_i up to, but not including, we_off_i. It stays high on reads.
- R4: On reads (write_i=0), oe_n_o is low for ticks oe_on_i up to, but not including, oe_off_i. It stays high on writes.
- R5: Only cs_n_o[cs_sel_i] is driven. It is low for ticks cs_on_i up to cs_wr_off_i on writes, and up to cs_rd_off_i on reads. The other five lines stay high.
- R6: The latch strobe is low for ticks lat_on_i up to lat_wr_off_i (writes) or lat_rd_off_i (reads). It appears on ale_n_o when cmd_i=0 and on cle_n_o when cmd_i=1. The unused pin stays high.
- R7: data_oe_o is high for every clock of a write cycle, from tick 0 to the end of the cycle. It is never high on reads.
- R8: The bits of half_i delay both edges of a strobe by half a clock. Bit 0 acts on chip select, bit 1 on write enable, bit 2 on output enable, and bit 3 on the latch strobe.
- R9: The settings are valid only if all of these hold:
  - cs_sel_i is below 6.
  - Each strobe used by the direction has its on tick below its off tick.
  - Each such off tick is at or below the cycle length.
  
  An idle start with invalid settings sets cfg_err_o and launches no cycle. The next accepted start clears cfg_err_o.
- R10: done_o is a single-clock pulse, one clock after the last clock of the cycle. It coincides with the fall of busy_o.
- R11: A start request while busy_o is high is ignored. Input changes during a cycle have no effect on that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Start request |
| write_i | input | 1 | 1 = write cycle, 0 = read cycle |
| cmd_i | input | 1 | Latch strobe goes to the command-latch pin when 1 |
| cs_sel_i | input | 3 | Chip-select line index |
| gran_i | input | 1 | Tick is two clocks when 1 |
| cs_on_i | input | 4 | Chip-select assert tick |
| cs_wr_off_i | input | 4 | Chip-select release tick, writes |
| cs_rd_off_i | input | 4 | Chip-select release tick, reads |
| lat_on_i | input | 4 | Latch strobe assert tick |
| lat_wr_off_i | input | 4 | Latch strobe release tick, writes |
| lat_rd_off_i | input | 4 | Latch strobe release tick, reads |
| we_on_i | input | 4 | Write-enable assert tick |
| we_off_i | input | 4 | Write-enable release tick |
| oe_on_i | input | 4 | Output-enable assert tick |
| oe_off_i | input | 4 | Output-enable release tick |
| wr_cyc_i | input | 4 | Write cycle length in ticks |
| rd_cyc_i | input | 4 | Read cycle length in ticks |
| half_i | input | 4 | Half-clock delay bits (cs, we, oe, latch) |
| cs_n_o | output | 6 | Chip selects, active low |
| we_n_o | output | 1 | Write enable, active low |
| oe_n_o | output | 1 | Output enable, active low |
| ale_n_o | output | 1 | Address-latch strobe, active low |
| cle_n_o | output | 1 | Command-latch strobe, active low |
| data_oe_o | output | 1 | Data bus drive enable |
| busy_o | output | 1 | Cycle in progress |
| done_o | output | 1 | End-of-cycle pulse |
| cfg_err_o | output | 1 | Last idle start had invalid settings |

## Verification
A stuck or miscounted tick counter shows up within one tick as a strobe edge in the wrong clock. A cycle length off by one moves done_o and the fall of busy_o by a full tick. A wrong latch of the direction, the select or the command bit shows up on the first clock of the cycle: the wrong enable, the wrong chip-select line or the wrong latch pin goes low. A half-delay stage that is misrouted or missing is seen half a clock after the edge, so every clock is sampled both before and after its falling edge.

// File: rtl/amct_pkg.sv
package amct_pkg;
  localparam int NUM_STROBES = 4;
  localparam int S_CS  = 0;
  localparam int S_WE  = 1;
  localparam int S_OE  = 2;
  localparam int S_LAT = 3;
endpackage

// File: rtl/amct_cfg_check.sv
module amct_cfg_check #(
  parameter int TW   = 4,
  parameter int NCS  = 6,
  parameter int SELW = 3
) (
  input  logic            write_i,
  input  logic [SELW-1:0] sel_i,
  input  logic [TW-1:0]   cs_on_i,
  input  logic [TW-1:0]   cs_wr_off_i,
  input  logic [TW-1:0]   cs_rd_off_i,
  input  logic [TW-1:0]   lat_on_i,
  input  logic [TW-1:0]   lat_wr_off_i,
  input  logic [TW-1:0]   lat_rd_off_i,
  input  logic [TW-1:0]   we_on_i,
  input  logic [TW-1:0]   we_off_i,
  input  logic [TW-1:0]   oe_on_i,
  input  logic [TW-1:0]   oe_off_i,
  input  logic [TW-1:0]   wr_cyc_i,
  input  logic [TW-1:0]   rd_cyc_i,
  output logic            ok_o
);
  localparam logic [SELW:0] SEL_LIMIT = (SELW+1)'(NCS);

  function automatic logic window_ok(logic [TW-1:0] on_t, logic [TW-1:0] off_t,
                                     logic [TW-1:0] cyc_t);
    return (on_t < off_t) && (off_t <= cyc_t);
  endfunction

  logic sel_ok, wr_ok, rd_ok;

  always_comb begin
    sel_ok = ({1'b0, sel_i} < SEL_LIMIT);
    wr_ok  = window_ok(cs_on_i, cs_wr_off_i, wr_cyc_i) &&
             window_ok(lat_on_i, lat_wr_off_i, wr_cyc_i) &&
             window_ok(we_on_i, we_off_i, wr_cyc_i);
    rd_ok  = window_ok(cs_on_i, cs_rd_off_i, rd_cyc_i) &&
             window_ok(lat_on_i, lat_rd_off_i, rd_cyc_i) &&
             window_ok(oe_on_i, oe_off_i, rd_cyc_i);
    ok_o   = sel_ok && (write_i ? wr_ok : rd_ok);
  end
endmodule

// File: rtl/amct_tick_gen.sv
module amct_tick_gen #(
  parameter int TW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          launch_i,
  input  logic          gran_i,
  input  logic [TW-1:0] cyc_i,
  output logic          run_o,
  output logic [TW-1:0] tick_o,
  output logic          fin_o
);
  logic          pre_q;
  logic [TW-1:0] last_tick;

  assign last_tick = cyc_i - 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_o  <= 1'b0;
      tick_o <= '0;
      pre_q  <= 1'b0;
      fin_o  <= 1'b0;
    end else begin
      fin_o <= 1'b0;
      if (launch_i) begin
        run_o  <= 1'b1;
        tick_o <= '0;
        pre_q  <= 1'b0;
      end else if (run_o) begin
        if (pre_q == gran_i) begin
          pre_q <= 1'b0;
          if (tick_o == last_tick) begin
            run_o <= 1'b0;
            fin_o <= 1'b1;
          end else begin
            tick_o <= tick_o + 1'b1;
          end
        end else begin
          pre_q <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/amct_strobe.sv
module amct_strobe #(
  parameter int TW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en_i,
  input  logic [TW-1:0] tick_i,
  input  logic [TW-1:0] on_i,
  input  logic [TW-1:0] off_i,
  input  logic          half_i,
  output logic          strobe_n_o
);
  logic act;
  logic rise_n_q;
  logic fall_n_q;

  assign act = en_i && (tick_i >= on_i) && (tick_i < off_i);

  always_ff @(posedge clk) begin
    if (rst) rise_n_q <= 1'b1;
    else     rise_n_q <= ~act;
  end

  always_ff @(negedge clk) begin
    if (rst) fall_n_q <= 1'b1;
    else     fall_n_q <= rise_n_q;
  end

  assign strobe_n_o = half_i ? fall_n_q : rise_n_q;
endmodule

// File: rtl/async_mem_strobe_seq.sv
module async_mem_strobe_seq
  import amct_pkg::*;
#(
  parameter int TW   = 4,
  parameter int NCS  = 6,
  parameter int SELW = (NCS > 1) ? $clog2(NCS) : 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   start_i,
  input  logic                   write_i,
  input  logic                   cmd_i,
  input  logic [SELW-1:0]        cs_sel_i,
  input  logic                   gran_i,
  input  logic [TW-1:0]          cs_on_i,
  input  logic [TW-1:0]          cs_wr_off_i,
  input  logic [TW-1:0]          cs_rd_off_i,
  input  logic [TW-1:0]          lat_on_i,
  input  logic [TW-1:0]          lat_wr_off_i,
  input  logic [TW-1:0]          lat_rd_off_i,
  input  logic [TW-1:0]          we_on_i,
  input  logic [TW-1:0]          we_off_i,
  input  logic [TW-1:0]          oe_on_i,
  input  logic [TW-1:0]          oe_off_i,
  input  logic [TW-1:0]          wr_cyc_i,
  input  logic [TW-1:0]          rd_cyc_i,
  input  logic [NUM_STROBES-1:0] half_i,
  output logic [NCS-1:0]         cs_n_o,
  output logic                   we_n_o,
  output logic                   oe_n_o,
  output logic                   ale_n_o,
  output logic                   cle_n_o,
  output logic                   data_oe_o,
  output logic                   busy_o,
  output logic                   done_o,
  output logic                   cfg_err_o
);
  logic                   cfg_ok;
  logic                   accept;
  logic                   run;
  logic                   fin;
  logic [TW-1:0]          tick;

  logic                   wr_q, cmd_q, gran_q;
  logic [SELW-1:0]        sel_q;
  logic [TW-1:0]          cyc_q;
  logic [NUM_STROBES-1:0] half_q;
  logic [TW-1:0]          on_q  [NUM_STROBES];
  logic [TW-1:0]          off_q [NUM_STROBES];
  logic [NUM_STROBES-1:0] en;
  logic [NUM_STROBES-1:0] strobe_n;

  amct_cfg_check #(.TW(TW), .NCS(NCS), .SELW(SELW)) u_check (
    .write_i      (write_i),
    .sel_i        (cs_sel_i),
    .cs_on_i      (cs_on_i),
    .cs_wr_off_i  (cs_wr_off_i),
    .cs_rd_off_i  (cs_rd_off_i),
    .lat_on_i     (lat_on_i),
    .lat_wr_off_i (lat_wr_off_i),
    .lat_rd_off_i (lat_rd_off_i),
    .we_on_i      (we_on_i),
    .we_off_i     (we_off_i),
    .oe_on_i      (oe_on_i),
    .oe_off_i     (oe_off_i),
    .wr_cyc_i     (wr_cyc_i),
    .rd_cyc_i     (rd_cyc_i),
    .ok_o         (cfg_ok)
  );

  assign busy_o = run | fin;
  assign accept = start_i && !busy_o && cfg_ok;

  // capture of the settings for the cycle being launched
  always_ff @(posedge clk) begin
    if (rst) begin
      wr_q   <= 1'b0;
      cmd_q  <= 1'b0;
      gran_q <= 1'b0;
      sel_q  <= '0;
      cyc_q  <= '0;
      half_q <= '0;
      for (int i = 0; i < NUM_STROBES; i++) begin
        on_q[i]  <= '0;
        off_q[i] <= '0;
      end
    end else if (accept) begin
      wr_q          <= write_i;
      cmd_q         <= cmd_i;
      gran_q        <= gran_i;
      sel_q         <= cs_sel_i;
      cyc_q         <= write_i ? wr_cyc_i : rd_cyc_i;
      half_q        <= half_i;
      on_q[S_CS]    <= cs_on_i;
      off_q[S_CS]   <= write_i ? cs_wr_off_i : cs_rd_off_i;
      on_q[S_WE]    <= we_on_i;
      off_q[S_WE]   <= we_off_i;
      on_q[S_OE]    <= oe_on_i;
      off_q[S_OE]   <= oe_off_i;
      on_q[S_LAT]   <= lat_on_i;
      off_q[S_LAT]  <= write_i ? lat_wr_off_i : lat_rd_off_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                      cfg_err_o <= 1'b0;
    else if (start_i && !busy_o)  cfg_err_o <= !cfg_ok;
  end

  amct_tick_gen #(.TW(TW)) u_ticks (
    .clk      (clk),
    .rst      (rst),
    .launch_i (accept),
    .gran_i   (gran_q),
    .cyc_i    (cyc_q),
    .run_o    (run),
    .tick_o   (tick),
    .fin_o    (fin)
  );

  always_comb begin
    en[S_CS]  = run;
    en[S_WE]  = run && wr_q;
    en[S_OE]  = run && !wr_q;
    en[S_LAT] = run;
  end

  for (genvar s = 0; s < NUM_STROBES; s++) begin : g_strobe
    amct_strobe #(.TW(TW)) u_strobe (
      .clk        (clk),
      .rst        (rst),
      .en_i       (en[s]),
      .tick_i     (tick),
      .on_i       (on_q[s]),
      .off_i      (off_q[s]),
      .half_i     (half_q[s]),
      .strobe_n_o (strobe_n[s])
    );
  end

  for (genvar c = 0; c < NCS; c++) begin : g_cs
    assign cs_n_o[c] = (sel_q == SELW'(c)) ? strobe_n[S_CS] : 1'b1;
  end

  assign we_n_o  = strobe_n[S_WE];
  assign oe_n_o  = strobe_n[S_OE];
  assign ale_n_o = cmd_q ? 1'b1 : strobe_n[S_LAT];
  assign cle_n_o = cmd_q ? strobe_n[S_LAT] : 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      data_oe_o <= 1'b0;
      done_o    <= 1'b0;
    end else begin
      data_oe_o <= run && wr_q;
      done_o    <= fin;
    end
  end
endmodule

module amct_checker #(
  parameter int NCS  = 6,
  parameter int SELW = 3
) (
  input logic            clk,
  input logic            rst,
  input logic            start_i,
  input logic [SELW-1:0] cs_sel_i,
  input logic [NCS-1:0]  cs_n_o,
  input logic            we_n_o,
  input logic            oe_n_o,
  input logic            ale_n_o,
  input logic            cle_n_o,
  input logic            data_oe_o,
  input logic            busy_o,
  input logic            done_o,
  input logic            cfg_err_o
);
  assert_one_cs_R5: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~cs_n_o));
  assert_we_oe_apart_R3: assert property (@(posedge clk) disable iff (rst)
    !(!we_n_o && !oe_n_o));
  assert_one_latch_pin_R6: assert property (@(posedge clk) disable iff (rst)
    !(!ale_n_o && !cle_n_o));
  assert_drive_in_cycle_R7: assert property (@(posedge clk) disable iff (rst)
    data_oe_o |-> busy_o);
  assert_done_single_R10: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
  assert_done_at_end_R10: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_o) |-> done_o);
  assert_bad_select_R9: assert property (@(posedge clk) disable iff (rst)
    (start_i && !busy_o && (int'(cs_sel_i) >= NCS)) |=> (!busy_o && cfg_err_o));
endmodule

bind async_mem_strobe_seq amct_checker #(.NCS(NCS), .SELW(SELW)) u_amct_checker (
  .clk       (clk),
  .rst       (rst),
  .start_i   (start_i),
  .cs_sel_i  (cs_sel_i),
  .cs_n_o    (cs_n_o),
  .we_n_o    (we_n_o),
  .oe_n_o    (oe_n_o),
  .ale_n_o   (ale_n_o),
  .cle_n_o   (cle_n_o),
  .data_oe_o (data_oe_o),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .cfg_err_o (cfg_err_o)
);

// File: tb/tb_async_mem_strobe_seq.sv
module tb_async_mem_strobe_seq;
  localparam int CLK_PERIOD = 10;
  localparam int TW = 4;
  localparam int NCS = 6;
  localparam int SELW = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0;
  logic write_i = 1'b0, cmd_i = 1'b0, gran_i = 1'b0;
  logic [SELW-1:0] cs_sel_i = '0;
  logic [TW-1:0] cs_on_i = '0, cs_wr_off_i = '0, cs_rd_off_i = '0;
  logic [TW-1:0] lat_on_i = '0, lat_wr_off_i = '0, lat_rd_off_i = '0;
  logic [TW-1:0] we_on_i = '0, we_off_i = '0, oe_on_i = '0, oe_off_i = '0;
  logic [TW-1:0] wr_cyc_i = '0, rd_cyc_i = '0;
  logic [3:0] half_i = '0;
  logic [NCS-1:0] cs_n_o;
  logic we_n_o, oe_n_o, ale_n_o, cle_n_o, data_oe_o, busy_o, done_o, cfg_err_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  async_mem_strobe_seq #(.TW(TW), .NCS(NCS), .SELW(SELW)) dut (.*);

  int checks = 0;
  int fails = 0;

  // model settings
  int m_wr, m_cmd, m_gran, m_sel, m_half;
  int m_cs_on, m_cs_wo, m_cs_ro, m_lat_on, m_lat_wo, m_lat_ro;
  int m_we_on, m_we_off, m_oe_on, m_oe_off, m_wcyc, m_rcyc;

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic apply();
    write_i = 1'(m_wr); cmd_i = 1'(m_cmd); gran_i = 1'(m_gran);
    cs_sel_i = SELW'(m_sel); half_i = 4'(m_half);
    cs_on_i = TW'(m_cs_on); cs_wr_off_i = TW'(m_cs_wo); cs_rd_off_i = TW'(m_cs_ro);
    lat_on_i = TW'(m_lat_on); lat_wr_off_i = TW'(m_lat_wo); lat_rd_off_i = TW'(m_lat_ro);
    we_on_i = TW'(m_we_on); we_off_i = TW'(m_we_off);
    oe_on_i = TW'(m_oe_on); oe_off_i = TW'(m_oe_off);
    wr_cyc_i = TW'(m_wcyc); rd_cyc_i = TW'(m_rcyc);
  endtask

  function automatic int cyc_clocks();
    return (m_wr != 0 ? m_wcyc : m_rcyc) * (m_gran + 1);
  endfunction

  // undelayed strobes for output clock k: {cs[5:0], we, oe, ale, cle}
  function automatic logic [9:0] strobes(int k);
    int t;
    bit run, cs_l, we_l, oe_l, lat_l;
    logic [5:0] cs;
    run = (k >= 1) && (k <= cyc_clocks());
    t = (k - 1) / (m_gran + 1);
    cs_l  = run && t >= m_cs_on && t < (m_wr != 0 ? m_cs_wo : m_cs_ro);
    we_l  = run && m_wr != 0 && t >= m_we_on && t < m_we_off;
    oe_l  = run && m_wr == 0 && t >= m_oe_on && t < m_oe_off;
    lat_l = run && t >= m_lat_on && t < (m_wr != 0 ? m_lat_wo : m_lat_ro);
    cs = 6'h3f;
    if (cs_l) cs[m_sel] = 1'b0;
    return {cs, !we_l, !oe_l, !(lat_l && m_cmd == 0), !(lat_l && m_cmd != 0)};
  endfunction

  // expected strobes at the sample before (late=0) or after (late=1) the falling edge
  function automatic logic [9:0] exp_strobes(int k, bit late);
    logic [9:0] now, prv, r;
    now = strobes(k);
    prv = strobes(k - 1);
    if (late) return now;
    r = now;
    if (m_half[0]) r[9:4] = prv[9:4];
    if (m_half[1]) r[3] = prv[3];
    if (m_half[2]) r[2] = prv[2];
    if (m_half[3]) r[1:0] = prv[1:0];
    return r;
  endfunction

  function automatic logic [9:0] act_strobes();
    return {cs_n_o, we_n_o, oe_n_o, ale_n_o, cle_n_o};
  endfunction

  task automatic sample(int k, bit late);
    int nt;
    nt = cyc_clocks();
    check(late ? "strobes late R3 R4 R5 R6 R8" : "strobes early R3 R4 R5 R6 R8",
          int'(act_strobes()), int'(exp_strobes(k, late)));
    check("drive R7", int'(data_oe_o), int'(m_wr != 0 && k >= 1 && k <= nt));
    check("busy/done R2 R10", int'({busy_o, done_o}),
          int'({k <= nt, k == nt + 1}));
  endtask

  // run one accepted cycle; poke=1 presents a start and scrambled inputs mid-cycle (R11)
  task automatic run_cycle(bit poke);
    int nt;
    nt = cyc_clocks();
    apply();
    @(negedge clk); start_i = 1'b1;
    @(posedge clk); #2; start_i = 1'b0;
    check("accept R2 R9", int'({busy_o, cfg_err_o}), 2);
    for (int k = 1; k <= nt + 1; k++) begin
      @(posedge clk); #2; sample(k, 1'b0);
      if (poke && k == 2) begin
        start_i = 1'b1; write_i = ~write_i; cmd_i = ~cmd_i; gran_i = ~gran_i;
        cs_sel_i = SELW'((m_sel + 1) % NCS); half_i = ~half_i;
        we_on_i = 0; oe_on_i = 0; cs_on_i = 0; lat_on_i = 0;
      end
      if (poke && k == 3) begin
        start_i = 1'b0; apply();
      end
      #5; sample(k, 1'b1);
    end
    if (poke) begin
      @(posedge clk); #2;
      check("start while busy ignored R11", int'({busy_o, done_o}), 0);
    end
  endtask

  task automatic try_bad(string what);
    apply();
    @(negedge clk); start_i = 1'b1;
    @(posedge clk); #2; start_i = 1'b0;
    check({"reject ", what, " R9"}, int'({busy_o, cfg_err_o}), 1);
    for (int k = 0; k < 3; k++) begin
      @(posedge clk); #2;
      check({"idle after reject R9 ", what}, int'({act_strobes(), data_oe_o, busy_o, done_o}),
            int'({10'h3ff, 3'b000}));
    end
  endtask

  task automatic timing_set(int ts);
    m_wcyc = 6 + 2 * ts; m_rcyc = 7 + ts;
    m_cs_on = (ts == 2) ? 1 : 0;
    m_cs_wo = m_wcyc - ((ts == 0) ? 0 : 1); m_cs_ro = m_rcyc;
    m_lat_on = ts; m_lat_wo = ts + 2; m_lat_ro = ts + 1;
    m_we_on = 1 + ts; m_we_off = m_wcyc - 1;
    m_oe_on = 2; m_oe_off = m_rcyc - ts;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    m_wr = 1; m_cmd = 0; m_gran = 0; m_sel = 0; m_half = 0;
    timing_set(0);
    apply();
    repeat (3) @(posedge clk);
    #2 rst = 1'b0;
    @(posedge clk); #2;
    // R1 reset state
    check("reset strobes R1", int'(act_strobes()), 10'h3ff);
    check("reset flags R1", int'({data_oe_o, busy_o, done_o, cfg_err_o}), 0);

    // sweep over direction, granularity, latch pin, delay bits, timing sets, selects
    for (int ts = 0; ts < 3; ts++)
      for (int g = 0; g < 2; g++)
        for (int w = 0; w < 2; w++)
          for (int c = 0; c < 2; c++)
            for (int p = 0; p < 4; p++) begin
              timing_set(ts);
              m_gran = g; m_wr = w; m_cmd = c; m_half = p * 5;
              m_sel = (ts * 16 + g * 8 + w * 4 + c * 2 + p) % NCS;
              run_cycle(1'b0);
            end

    // R11: start and input changes during a cycle
    timing_set(1); m_gran = 1; m_wr = 1; m_cmd = 0; m_half = 4'b1010; m_sel = 5;
    run_cycle(1'b1);
    m_wr = 0; m_cmd = 1; m_gran = 0; m_half = 4'b0101; m_sel = 2;
    run_cycle(1'b1);

    // R9: invalid settings
    timing_set(0); m_gran = 0; m_half = 0;
    m_wr = 1; m_sel = 6; try_bad("select 6");
    m_sel = 7; try_bad("select 7");
    m_sel = 1; m_we_off = m_we_on; try_bad("we window empty");
    timing_set(0); m_wr = 0; m_oe_off = m_rcyc + 1; try_bad("oe past cycle");
    timing_set(0); m_wr = 1; m_lat_wo = m_wcyc + 1; try_bad("latch past cycle");
    // a valid start clears the error flag (checked inside run_cycle)
    timing_set(2); m_wr = 0; m_sel = 3;
    run_cycle(1'b0);
    // boundary: longest cycle of the counter width, off ticks equal to cycle
    m_wr = 1; m_gran = 1; m_wcyc = 15; m_cs_on = 0; m_cs_wo = 15;
    m_we_on = 14; m_we_off = 15; m_lat_on = 0; m_lat_wo = 1; m_sel = 4; m_half = 15;
    run_cycle(1'b0);
    finish_run();
  end
endmodule